// File: doc/BRIEF.md
# Integer Execution Unit with Set-Compare and Load-High

This block is the integer execution stage of a classic load/store RISC pipeline. It is purely combinational: it takes the first source operand, a register value or a 16-bit immediate as the second operand, an operation code and a signed/unsigned qualifier. It returns a 32-bit result together with a signed-overflow flag in the same cycle.

Besides the usual add, subtract, bitwise and shift operations, the unit folds in two less common paths. Six set-on-comparison operations write the value 1 or 0. A load-high path places the immediate in the upper half of the result and clears the lower half.

The second operand is chosen inside the unit. The immediate is widened by sign or zero extension according to the operation, so decode logic only forwards raw instruction fields. There is no clock, no handshake and no state. Whatever sits around the unit registers its inputs and result, so it never stalls and back-pressure does not apply.

Top module: `rx_int_alu`

## Requirements
- R1: Operation code 0 (add) returns a + b and code 1 (subtract) returns a - b, both wrapped to 32 bits, whatever the value of the unsigned qualifier `uns_i`.
- R2: `ovf_o` is 1 only for codes 0 and 1 with `uns_i` = 0 when the two's-complement result does not fit in 32 bits; it is 0 for every other operation and whenever `uns_i` = 1.
- R3: With `use_imm_i` = 1 the second operand comes from `imm_i`. It is zero-extended for codes 2, 3 and 4, and for codes 0 and 1 when `uns_i` = 1. It is sign-extended for every other code.
- R4: Codes 2, 3 and 4 return the bitwise AND, OR and XOR of the two operands.
- R5: Code 14 (load-high) returns `imm_i` in bits 31:16 and zero in bits 15:0. The first operand, `use_imm_i` and `uns_i` have no effect on it.
- R6: Code 5 shifts left logically, code 6 shifts right logically and code 7 shifts right arithmetically, copying bit 31 into vacated bits. Only bits 4:0 of the second operand give the amount.
- R7: A shift whose amount bits 4:0 are zero returns the first operand unchanged, even if the upper bits of the second operand are set.
- R8: Codes 8 to 13 (less-than, greater-than, less-or-equal, greater-or-equal, equal, not-equal) return 1 when the condition holds and 0 otherwise. With `uns_i` = 0 the operands are compared as signed values.
- R9: With `uns_i` = 1, codes 8 to 11 compare the operands as unsigned 32-bit values.
- R10: Code 15 is reserved and returns a zero result with `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First source operand |
| b_reg_i | input | 32 | Second source operand when the register form is used |
| imm_i | input | 16 | Immediate field of the instruction |
| use_imm_i | input | 1 | 1 selects the extended immediate as the second operand |
| op_i | input | 4 | Operation code, encoded as listed in the requirements |
| uns_i | input | 1 | 1 selects unsigned arithmetic and unsigned comparison |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench drives the operand pairs where signed and unsigned readings disagree: 0x7FFFFFFF against 0x80000000, all-ones against one, and equal values at each comparison boundary. A design that takes the less-than verdict from the wrong carry or sign term returns the inverted bit for exactly these pairs. The cases that separate the extension rules are an immediate with bit 15 set under the AND, unsigned add and signed compare forms. A unit that extends with the wrong rule would be off by 0xFFFF0000 in the result. Shift amounts of 0, 31 and values with bit 5 set catch a shifter that uses too many amount bits or fills with the wrong bit. Overflow is checked on both sides of the signed limit and under the unsigned qualifier, where a flag leaking through would be reported.

// File: rtl/rx_alu_pkg.sv
package rx_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SLL = 4'd5,
    OP_SRL = 4'd6,
    OP_SRA = 4'd7,
    OP_SLT = 4'd8,
    OP_SGT = 4'd9,
    OP_SLE = 4'd10,
    OP_SGE = 4'd11,
    OP_SEQ = 4'd12,
    OP_SNE = 4'd13,
    OP_LHI = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic op_is_logic(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_shift(input alu_op_e op);
    return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  endfunction

  function automatic logic op_is_cmp(input alu_op_e op);
    return (op >= OP_SLT) && (op <= OP_SNE);
  endfunction

endpackage

// File: rtl/rx_alu_opnd_sel.sv
module rx_alu_opnd_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] b_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              zext,
  output logic [DATA_W-1:0] b_eff
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_wide;
  logic              pad_bit;

  // extension bit: zero for the zero-extended forms, else the immediate sign
  assign pad_bit  = zext ? 1'b0 : imm[IMM_W-1];
  assign imm_wide = {{PAD_W{pad_bit}}, imm};
  assign b_eff    = use_imm ? imm_wide : b_reg;

endmodule

// File: rtl/rx_alu_addsub.sv
module rx_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  logic [DATA_W-1:0] b_inv;
  logic [DATA_W:0]   wide;

  assign b_inv = sub ? ~b : b;
  // a + b_inv + sub: subtraction as two's-complement add
  assign wide  = {1'b0, a} + {1'b0, b_inv} + {{DATA_W{1'b0}}, sub};
  assign sum   = wide[DATA_W-1:0];
  assign carry = wide[DATA_W];
  // operands agree in sign after inversion and the sum disagrees
  assign ovf   = (a[DATA_W-1] == b_inv[DATA_W-1]) &&
                 (sum[DATA_W-1] != a[DATA_W-1]);

endmodule

// File: rtl/rx_alu_shift.sv
module rx_alu_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   amt,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] a_rev;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] out_rev;
  logic              fill;

  // left shifts reuse the right shifter on bit-reversed data
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign a_rev[i]   = a[DATA_W-1-i];
    assign out_rev[i] = stage[SH_W][DATA_W-1-i];
  end

  assign fill     = arith & ~left & a[DATA_W-1];
  assign stage[0] = left ? a_rev : a;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ?
                        {{STEP{fill}}, stage[k][DATA_W-1:STEP]} :
                        stage[k];
  end

  assign y = left ? out_rev : stage[SH_W];

endmodule

// File: rtl/rx_alu_cmp.sv
module rx_alu_cmp #(
  parameter int DATA_W = 32
) (
  input  rx_alu_pkg::alu_op_e op,
  input  logic              uns,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] diff,
  input  logic              carry,
  input  logic              ovf,
  output logic              flag
);
  import rx_alu_pkg::*;

  logic eq;
  logic lt;

  assign eq = (a == b);
  // unsigned: borrow means a < b; signed: diff sign corrected by overflow
  assign lt = uns ? ~carry : (diff[DATA_W-1] ^ ovf);

  always_comb begin
    unique case (op)
      OP_SLT:  flag = lt;
      OP_SGT:  flag = ~lt & ~eq;
      OP_SLE:  flag = lt | eq;
      OP_SGE:  flag = ~lt;
      OP_SEQ:  flag = eq;
      OP_SNE:  flag = ~eq;
      default: flag = 1'b0;
    endcase
  end

endmodule

// File: rtl/rx_int_alu.sv
module rx_int_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              uns_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);
  import rx_alu_pkg::*;

  localparam int SH_W  = $clog2(DATA_W);
  localparam int LOW_W = DATA_W - IMM_W;

  alu_op_e           op;
  logic              zext;
  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              ovf_raw;
  logic [DATA_W-1:0] sh_out;
  logic              cmp_flag;
  logic [DATA_W-1:0] lhi_val;

  assign op     = alu_op_e'(op_i);
  assign zext   = op_is_logic(op) || (op_is_arith(op) && uns_i);
  // the shared adder subtracts for everything except add
  assign do_sub = (op != OP_ADD);

  rx_alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .b_reg   (b_reg_i),
    .imm     (imm_i),
    .use_imm (use_imm_i),
    .zext    (zext),
    .b_eff   (b_eff)
  );

  rx_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a     (a_i),
    .b     (b_eff),
    .sub   (do_sub),
    .sum   (sum),
    .carry (carry),
    .ovf   (ovf_raw)
  );

  rx_alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .a     (a_i),
    .amt   (b_eff[SH_W-1:0]),
    .left  (op == OP_SLL),
    .arith (op == OP_SRA),
    .y     (sh_out)
  );

  rx_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .op    (op),
    .uns   (uns_i),
    .a     (a_i),
    .b     (b_eff),
    .diff  (sum),
    .carry (carry),
    .ovf   (ovf_raw),
    .flag  (cmp_flag)
  );

  assign lhi_val = {imm_i, {LOW_W{1'b0}}};

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:                 result_o = sum;
      OP_AND:                         result_o = a_i & b_eff;
      OP_OR:                          result_o = a_i | b_eff;
      OP_XOR:                         result_o = a_i ^ b_eff;
      OP_SLL, OP_SRL, OP_SRA:         result_o = sh_out;
      OP_SLT, OP_SGT, OP_SLE,
      OP_SGE, OP_SEQ, OP_SNE:         result_o = {{(DATA_W-1){1'b0}}, cmp_flag};
      OP_LHI:                         result_o = lhi_val;
      default:                        result_o = '0;
    endcase
  end

  assign ovf_o = op_is_arith(op) & ~uns_i & ovf_raw;

endmodule

// File: rtl/rx_int_alu_chk.sv
module rx_int_alu_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OP_W   = 4
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_reg_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              use_imm_i,
  input logic [OP_W-1:0]   op_i,
  input logic              uns_i,
  input logic [DATA_W-1:0] result_o,
  input logic              ovf_o
);
  localparam int SH_W = $clog2(DATA_W);

  always_comb begin
    // R5: load-high places the immediate on top and clears the rest
    if (op_i == 4'd14) begin
      a_r5_lhi_layout: assert (result_o[DATA_W-1:DATA_W-IMM_W] == imm_i &&
                               result_o[DATA_W-IMM_W-1:0] == '0)
        else $error("load-high layout wrong");
    end
    // R8: comparisons yield only 0 or 1
    if (op_i >= 4'd8 && op_i <= 4'd13) begin
      a_r8_cmp_boolean: assert (result_o[DATA_W-1:1] == '0)
        else $error("compare result not boolean");
    end
    // R2: overflow confined to signed add/subtract
    if (op_i > 4'd1 || uns_i) begin
      a_r2_no_overflow: assert (!ovf_o)
        else $error("overflow outside signed add/sub");
    end
    // R2: signed register add overflow only when sign flips against equal-signed inputs
    if (op_i == 4'd0 && !use_imm_i && ovf_o) begin
      a_r2_add_ovf_sign: assert (a_i[DATA_W-1] == b_reg_i[DATA_W-1] &&
                                 result_o[DATA_W-1] != a_i[DATA_W-1])
        else $error("add overflow without sign flip");
    end
    // R7: zero shift amount passes the operand through
    if (op_i >= 4'd5 && op_i <= 4'd7 && !use_imm_i && b_reg_i[SH_W-1:0] == '0) begin
      a_r7_zero_shift: assert (result_o == a_i)
        else $error("zero shift altered operand");
    end
    // R10: reserved code yields zero
    if (op_i == 4'd15) begin
      a_r10_reserved_zero: assert (result_o == '0 && !ovf_o)
        else $error("reserved code not zero");
    end
  end

endmodule

bind rx_int_alu rx_int_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OP_W(OP_W)) u_chk (
  .a_i       (a_i),
  .b_reg_i   (b_reg_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .op_i      (op_i),
  .uns_i     (uns_i),
  .result_o  (result_o),
  .ovf_o     (ovf_o)
);

// File: tb/rx_int_alu_test.sv
`timescale 1ns/1ps
module rx_int_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_i = '0;
  logic [31:0] b_reg_i = '0;
  logic [15:0] imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        uns_i = 1'b0;
  logic [31:0] result_o;
  logic        ovf_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_int_alu uut (
    .a_i(a_i), .b_reg_i(b_reg_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
    .op_i(op_i), .uns_i(uns_i), .result_o(result_o), .ovf_o(ovf_o)
  );

  // behavioural reference: {ovf, result}
  function automatic logic [32:0] model(input int op, input logic [31:0] a,
                                         input logic [31:0] breg, input logic [15:0] imm,
                                         input logic ui, input logic us);
    logic [31:0] b;
    longint sa, sb, ua, ub, s, x, y;
    logic [31:0] r;
    logic v;
    int amt;
    b = breg;
    if (ui) begin
      if (op == 2 || op == 3 || op == 4 || (us && (op == 0 || op == 1)))
        b = {16'h0, imm};
      else
        b = {{16{imm[15]}}, imm};
    end
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'h0, a});
    ub = longint'({32'h0, b});
    x  = us ? ua : sa;
    y  = us ? ub : sb;
    amt = int'(b[4:0]);
    r = 0;
    v = 0;
    case (op)
      0: begin s = sa + sb; r = a + b; v = !us && (s > 64'sd2147483647 || s < -64'sd2147483648); end
      1: begin s = sa - sb; r = a - b; v = !us && (s > 64'sd2147483647 || s < -64'sd2147483648); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = a << amt;
      6: r = a >> amt;
      7: r = 32'($signed(a) >>> amt);
      8: r = (x <  y) ? 1 : 0;
      9: r = (x >  y) ? 1 : 0;
      10: r = (x <= y) ? 1 : 0;
      11: r = (x >= y) ? 1 : 0;
      12: r = (a == b) ? 1 : 0;
      13: r = (a != b) ? 1 : 0;
      14: r = {imm, 16'h0};
      default: r = 0;
    endcase
    return {v, r};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R1";
      2, 3, 4: return "R4";
      5, 6, 7: return "R6";
      8, 9, 10, 11, 12, 13: return "R8";
      14: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input int op, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] imm, input logic ui, input logic us,
                     input logic [31:0] exp_r, input logic exp_v, input string tag);
    @(posedge clk);
    #2;
    op_i = op[3:0]; a_i = a; b_reg_i = b; imm_i = imm; use_imm_i = ui; uns_i = us;
    @(negedge clk);
    n_chk++;
    if (result_o !== exp_r || ovf_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b us=%0b: got %h/%0b expected %h/%0b",
               tag, op, a, b, imm, ui, us, result_o, ovf_o, exp_r, exp_v);
    end
  endtask

  task automatic runm(input int op, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] imm, input logic ui, input logic us, input string tag);
    logic [32:0] e;
    e = model(op, a, b, imm, ui, us);
    run(op, a, b, imm, ui, us, e[31:0], e[32], tag);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs give zero, no overflow (R1)
    @(negedge clk);
    n_chk++;
    if (result_o !== 32'h0 || ovf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state: got %h/%0b expected 00000000/0", result_o, ovf_o);
    end

    // R1 wrap in both forms
    run(0, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 1, 32'h0, 0, "R1");
    run(1, 32'h0, 32'h1, 16'h0, 0, 1, 32'hFFFF_FFFF, 0, "R1");
    run(0, 32'h1234_5678, 32'h1111_1111, 16'h0, 0, 0, 32'h2345_6789, 0, "R1");
    // R2 overflow
    run(0, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, 32'h8000_0000, 1, "R2");
    run(1, 32'h8000_0000, 32'h1, 16'h0, 0, 0, 32'h7FFF_FFFF, 1, "R2");
    run(0, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 1, 32'h8000_0000, 0, "R2");
    run(0, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 32'h0, 0, "R2");
    run(8, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 0, 0, 32'h0, 0, "R2");
    // R3 immediate extension
    run(0, 32'h10, 32'h0, 16'hFFFF, 1, 0, 32'hF, 0, "R3");
    run(0, 32'h10, 32'h0, 16'hFFFF, 1, 1, 32'h0001_000F, 0, "R3");
    run(2, 32'hFFFF_FFFF, 32'h0, 16'h8000, 1, 0, 32'h0000_8000, 0, "R3");
    run(8, 32'h0, 32'h0, 16'hFFFF, 1, 0, 32'h0, 0, "R3");
    run(8, 32'h5, 32'h0, 16'hFFFF, 1, 1, 32'h1, 0, "R3");
    // R4 logical
    run(2, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 0, 0, 32'hF000_F000, 0, "R4");
    run(3, 32'hF0F0_F0F0, 32'h0F00_000F, 16'h0, 0, 0, 32'hFFF0_F0FF, 0, "R4");
    run(4, 32'hAAAA_AAAA, 32'hFFFF_0000, 16'h0, 0, 0, 32'h5555_AAAA, 0, "R4");
    // R5 load-high
    run(14, 32'hDEAD_BEEF, 32'h0, 16'h0042, 1, 0, 32'h0042_0000, 0, "R5");
    run(14, 32'h1, 32'hFFFF_FFFF, 16'hBEEF, 0, 1, 32'hBEEF_0000, 0, "R5");
    // R6 shifts
    run(5, 32'h1, 32'h21, 16'h0, 0, 0, 32'h2, 0, "R6");
    run(7, 32'h8000_0000, 32'h4, 16'h0, 0, 0, 32'hF800_0000, 0, "R6");
    run(6, 32'h8000_0000, 32'h4, 16'h0, 0, 0, 32'h0800_0000, 0, "R6");
    run(7, 32'h8000_0000, 32'h0, 16'h001F, 1, 0, 32'hFFFF_FFFF, 0, "R6");
    run(5, 32'h1, 32'h1F, 16'h0, 0, 0, 32'h8000_0000, 0, "R6");
    // R7 zero amount
    run(7, 32'h8765_4321, 32'hFFFF_FFE0, 16'h0, 0, 0, 32'h8765_4321, 0, "R7");
    run(5, 32'h8765_4321, 32'h0, 16'h0020, 1, 0, 32'h8765_4321, 0, "R7");
    // R8 signed compares
    run(8,  32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 32'h1, 0, "R8");
    run(9,  32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 32'h0, 0, "R8");
    run(10, 32'h5, 32'h5, 16'h0, 0, 0, 32'h1, 0, "R8");
    run(11, 32'h4, 32'h5, 16'h0, 0, 0, 32'h0, 0, "R8");
    run(12, 32'h5, 32'h0, 16'h0005, 1, 0, 32'h1, 0, "R8");
    run(13, 32'h7, 32'h0, 16'h0007, 1, 0, 32'h0, 0, "R8");
    run(8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, 32'h1, 0, "R8");
    // R9 unsigned compares
    run(8, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 1, 32'h0, 0, "R9");
    run(9, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 1, 32'h1, 0, "R9");
    run(10, 32'h1, 32'hFFFF_FFFF, 16'h0, 0, 1, 32'h1, 0, "R9");
    run(11, 32'h1, 32'hFFFF_FFFF, 16'h0, 0, 1, 32'h0, 0, "R9");
    // R10 reserved
    run(15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 0, 0, 32'h0, 0, "R10");
    run(15, 32'h7FFF_FFFF, 32'h1, 16'h1, 1, 1, 32'h0, 0, "R10");

    // random sweep against the reference model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 15));
      runm(op, pick(), pick(), 16'($urandom), 1'($urandom), 1'($urandom), tag_of(op));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule